// File: doc/BRIEF.md
# Smart Card Character Receiver

This block is the receive half of a half-duplex smart card link that carries one character at a time. It watches the single shared I/O line. Each character it frames has a low start bit, eight data bits sent least significant bit first, and an even parity bit. The block samples each bit at the middle of its elementary time unit (ETU), whose length in clock cycles is a fixed parameter. A character with good parity goes into a receive data register and raises a data-ready flag. A character with bad parity raises a parity error flag. The receiver then pulls the line low for a short time after the parity bit, which asks the sender to repeat the character.

A transfer agent empties the data register with a read strobe, and software clears the two error flags with their own strobes. A receive interrupt and an error interrupt come from the flags. Both are gated by a single receive interrupt enable. The data register keeps the byte of a bad-parity character, so software can still read it.

Top module: `sc_char_rx`

## Requirements
- R1: After a synchronous active-low reset, rx_data is 0, rx_full, par_err, ovr_err, rx_irq, err_irq and io_drive_low are all 0.
- R2: A character is a low start bit, D0..D7 least significant bit first, then a parity bit P, each ETU cycles long. Parity is good when D0..D7 and P hold an even number of ones. Let k be the first rising clock edge at which io_line is seen low. The outcome of the character shows on the outputs right after edge k + 3 + ETU/2 + 9*ETU. A good character, with all three flags clear, loads rx_data with D7..D0 and sets rx_full.
- R3: A character with bad parity sets par_err, loads its byte into rx_data and leaves rx_full unchanged.
- R4: After a bad-parity character, io_drive_low is 1 after edges k + 2 + 10*ETU through k + 1 + 10*ETU + ERR_ETUS*ETU, and 0 at all other times. io_drive_low never rises after a good character.
- R5: After the error signal, the receiver waits until the line reads high again. It then frames the repeated character normally.
- R6: A good character that completes while rx_full is 1 and both error flags are clear sets ovr_err and leaves rx_data unchanged.
- R7: A good character that completes while par_err or ovr_err is 1 is discarded. rx_data and rx_full do not change.
- R8: rd_strobe clears rx_full, per_clr clears par_err and ovr_clr clears ovr_err, each at the clock edge that samples the strobe. A flag being set wins over a clear at the same edge.
- R9: rx_irq is rx_full AND rx_ie. err_irq is (par_err OR ovr_err) AND rx_ie.
- R10: A low pulse on io_line that ends before the middle of the start bit is ignored. The outputs do not change, and a later character is received normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_line | input | 1 | Level of the shared I/O line |
| io_drive_low | output | 1 | 1 = pull the I/O line low (error signal) |
| rx_ie | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | One-cycle read of the data register; clears rx_full |
| per_clr | input | 1 | Clears par_err |
| ovr_clr | input | 1 | Clears ovr_err |
| rx_data | output | 8 | Receive data register |
| rx_full | output | 1 | Receive data register holds an unread good byte |
| par_err | output | 1 | Parity error flag |
| ovr_err | output | 1 | Overrun error flag |
| rx_irq | output | 1 | Receive interrupt |
| err_irq | output | 1 | Error interrupt |

## Verification
The hardest cases to reach from the ports are the ones where the block's own error signal pulls down the line it is also listening to. The bench models the line as wired-AND: the sender's level ANDed with the inverse of io_drive_low. This lets the receiver's recovery wait after a bad-parity character run just as it would on a real line. The bench then repeats the same byte with correct parity. Sticky-flag cases are built by chaining characters without reading or clearing in between. This covers an overrun followed by a discarded character, and a good character that arrives while a parity error is still pending.

// File: rtl/sc_rx_pkg.sv
// Package: shared constants and types for the smart card character receiver.
// Assumes one fixed character format: 8 data bits plus one parity bit.
package sc_rx_pkg;

    localparam int SC_DATA_BITS  = 8;
    localparam int SC_FRAME_BITS = SC_DATA_BITS + 1;

    // Framer sequencing states
    typedef enum logic [2:0] {
        FR_IDLE    = 3'd0,
        FR_START   = 3'd1,
        FR_BITS    = 3'd2,
        FR_TAIL    = 3'd3,
        FR_ERRSIG  = 3'd4,
        FR_RECOVER = 3'd5
    } fr_state_t;

    // One completed character as handed from framer to status logic
    typedef struct packed {
        logic [SC_DATA_BITS-1:0] data;
        logic                    par_ok;
    } rx_char_t;

endpackage

// File: rtl/sc_rx_sync.sv
// Module: sc_rx_sync
// Brings the asynchronous I/O line into the clock domain through a flop chain.
// Assumes STAGES >= 2. The chain resets to 1, the idle level of the line.
module sc_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    // Shift the line level through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/sc_rx_framer.sv
// Module: sc_rx_framer
// Detects the start bit and samples nine bits at mid-ETU. It reports each finished
// character as a one-cycle pulse, and drives the error signal after a bad parity bit.
// Assumes line_s is already synchronized. CLKS_PER_ETU is even and at least 4.
module sc_rx_framer
    import sc_rx_pkg::*;
#(
    parameter int CLKS_PER_ETU = 16,
    parameter int ERR_ETUS     = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     line_s,
    output logic     char_done,
    output rx_char_t char_out,
    output logic     drive_low
);

    localparam int HALF_ETU = CLKS_PER_ETU / 2;
    localparam int ERR_LEN  = ERR_ETUS * CLKS_PER_ETU;
    localparam int MAX_CNT  = (ERR_LEN > CLKS_PER_ETU) ? ERR_LEN : CLKS_PER_ETU;
    localparam int CW       = $clog2(MAX_CNT + 1);
    localparam int IW       = $clog2(SC_FRAME_BITS + 1);

    localparam logic [CW-1:0] HALF_LAST = CW'(HALF_ETU - 1);
    localparam logic [CW-1:0] ETU_LAST  = CW'(CLKS_PER_ETU - 1);
    localparam logic [CW-1:0] ERR_LAST  = CW'(ERR_LEN - 1);
    localparam logic [IW-1:0] IDX_LAST  = IW'(SC_FRAME_BITS - 1);

    fr_state_t                state;
    logic [CW-1:0]            cnt;
    logic [IW-1:0]            bit_idx;
    logic [SC_FRAME_BITS-1:0] shreg;
    logic                     done_q;
    logic                     par_ok;

    // Even parity over the eight data bits and the parity bit
    always_comb begin
        par_ok = ~(^shreg);
    end

    // Sequence one character: start check, bit sampling, tail, error signal, recovery
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= FR_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                FR_IDLE: begin
                    cnt <= '0;
                    if (!line_s) begin
                        state <= FR_START;
                    end
                end
                FR_START: begin
                    if (cnt == HALF_LAST) begin
                        cnt     <= '0;
                        bit_idx <= '0;
                        state   <= line_s ? FR_IDLE : FR_BITS;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                FR_BITS: begin
                    if (cnt == ETU_LAST) begin
                        cnt     <= '0;
                        shreg   <= {line_s, shreg[SC_FRAME_BITS-1:1]};
                        bit_idx <= bit_idx + 1'b1;
                        if (bit_idx == IDX_LAST) begin
                            done_q <= 1'b1;
                            state  <= FR_TAIL;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                FR_TAIL: begin
                    if (cnt == HALF_LAST) begin
                        cnt   <= '0;
                        state <= par_ok ? FR_RECOVER : FR_ERRSIG;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                FR_ERRSIG: begin
                    if (cnt == ERR_LAST) begin
                        cnt   <= '0;
                        state <= FR_RECOVER;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                FR_RECOVER: begin
                    cnt <= '0;
                    if (line_s) begin
                        state <= FR_IDLE;
                    end
                end
                default: state <= FR_IDLE;
            endcase
        end
    end

    assign char_done      = done_q;
    assign char_out.data  = shreg[SC_DATA_BITS-1:0];
    assign char_out.par_ok = par_ok;
    assign drive_low      = (state == FR_ERRSIG);

    // R2: the completion pulse lasts exactly one cycle
    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |=> !char_done);

    // R4: the error signal only starts after a character with bad parity
    assert_drive_after_bad_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_low) |-> !char_out.par_ok);

endmodule

// File: rtl/sc_rx_status.sv
// Module: sc_rx_status
// Holds the receive data register and the three status flags, and forms the
// two interrupts. Assumes char_done is a one-cycle pulse with char_in valid.
module sc_rx_status
    import sc_rx_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    char_done,
    input  rx_char_t                char_in,
    input  logic                    rd_strobe,
    input  logic                    per_clr,
    input  logic                    ovr_clr,
    input  logic                    rx_ie,
    output logic [SC_DATA_BITS-1:0] rx_data,
    output logic                    rx_full,
    output logic                    par_err,
    output logic                    ovr_err,
    output logic                    rx_irq,
    output logic                    err_irq
);

    logic [SC_DATA_BITS-1:0] data_q;
    logic                    full_q;
    logic                    per_q;
    logic                    ovr_q;

    // Apply the clears first, then let a completed character's outcome override them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            full_q <= 1'b0;
            per_q  <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (rd_strobe) full_q <= 1'b0;
            if (per_clr)   per_q  <= 1'b0;
            if (ovr_clr)   ovr_q  <= 1'b0;
            if (char_done) begin
                if (!char_in.par_ok) begin
                    data_q <= char_in.data;
                    per_q  <= 1'b1;
                end else if (per_q || ovr_q) begin
                    data_q <= data_q;
                end else if (full_q) begin
                    ovr_q <= 1'b1;
                end else begin
                    data_q <= char_in.data;
                    full_q <= 1'b1;
                end
            end
        end
    end

    // Interrupt outputs, gated by the enable
    always_comb begin
        rx_irq  = full_q & rx_ie;
        err_irq = (per_q | ovr_q) & rx_ie;
    end

    assign rx_data = data_q;
    assign rx_full = full_q;
    assign par_err = per_q;
    assign ovr_err = ovr_q;

    // R2: a clean good character raises the data-ready flag
    assert_good_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && char_in.par_ok && !per_q && !ovr_q && !full_q) |=> full_q);

    // R3: a bad character flags parity and leaves data-ready alone
    assert_bad_keeps_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && !char_in.par_ok && !rd_strobe) |=> (per_q && $stable(full_q)));

    // R6: an overrun keeps the old byte
    assert_overrun_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && char_in.par_ok && full_q && !per_q && !ovr_q && !ovr_clr)
        |=> (ovr_q && $stable(data_q)));

    // R7: a good character arriving with a pending error is dropped
    assert_discard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && char_in.par_ok && (per_q || ovr_q) && !rd_strobe)
        |=> ($stable(data_q) && $stable(full_q)));

    // R8: a read without a completing character empties the register
    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !char_done) |=> !full_q);

endmodule

// File: rtl/sc_char_rx.sv
// Module: sc_char_rx (top)
// Smart card character receiver: synchronizer, framer with error signalling,
// and the status/data register. Assumes the I/O line is pulled up externally
// and that io_drive_low enables an open-drain pull-down.
module sc_char_rx
    import sc_rx_pkg::*;
#(
    parameter int CLKS_PER_ETU = 16,
    parameter int ERR_ETUS     = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    io_line,
    output logic                    io_drive_low,
    input  logic                    rx_ie,
    input  logic                    rd_strobe,
    input  logic                    per_clr,
    input  logic                    ovr_clr,
    output logic [SC_DATA_BITS-1:0] rx_data,
    output logic                    rx_full,
    output logic                    par_err,
    output logic                    ovr_err,
    output logic                    rx_irq,
    output logic                    err_irq
);

    logic     line_s;
    logic     char_done;
    rx_char_t char_bus;

    sc_rx_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (io_line),
        .sync_out (line_s)
    );

    sc_rx_framer #(
        .CLKS_PER_ETU (CLKS_PER_ETU),
        .ERR_ETUS     (ERR_ETUS)
    ) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_s    (line_s),
        .char_done (char_done),
        .char_out  (char_bus),
        .drive_low (io_drive_low)
    );

    sc_rx_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .char_done (char_done),
        .char_in   (char_bus),
        .rd_strobe (rd_strobe),
        .per_clr   (per_clr),
        .ovr_clr   (ovr_clr),
        .rx_ie     (rx_ie),
        .rx_data   (rx_data),
        .rx_full   (rx_full),
        .par_err   (par_err),
        .ovr_err   (ovr_err),
        .rx_irq    (rx_irq),
        .err_irq   (err_irq)
    );

    // R4: the error signal never coincides with a freshly completed character
    assert_drive_quiet_at_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |-> !io_drive_low);

endmodule

// File: tb/sc_char_rx_bench.sv
`timescale 1ns/1ps
// Bench: behavioural line sender plus a reference model, compared on every clock.
module sc_char_rx_bench;

    localparam int ETU    = 16;
    localparam int ERRE   = 2;
    localparam int HALF   = ETU / 2;
    localparam int ERRLEN = ERRE * ETU;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_level = 1'b1;
    logic       io_line;
    logic       io_drive_low;
    logic       rx_ie = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       per_clr = 1'b0;
    logic       ovr_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, par_err, ovr_err, rx_irq, err_irq;

    // reference model state
    logic [7:0] m_data = 8'h00;
    logic       m_full = 1'b0, m_per = 1'b0, m_ovr = 1'b0, m_drive = 1'b0;
    logic       cmp_en = 1'b0;
    int         vectors = 0;
    int         fails = 0;

    // wired-AND line: sender level, pulled low by the receiver's error signal
    assign io_line = tx_level & ~io_drive_low;

    always #2.5 clk = ~clk;

    sc_char_rx #(.CLKS_PER_ETU(ETU), .ERR_ETUS(ERRE)) u_sc_char_rx (
        .clk(clk), .rst_n(rst_n), .io_line(io_line), .io_drive_low(io_drive_low),
        .rx_ie(rx_ie), .rd_strobe(rd_strobe), .per_clr(per_clr), .ovr_clr(ovr_clr),
        .rx_data(rx_data), .rx_full(rx_full), .par_err(par_err), .ovr_err(ovr_err),
        .rx_irq(rx_irq), .err_irq(err_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (cmp_en) begin
            check("R2 rx_data", rx_data, m_data);
            check("R2 rx_full", rx_full, m_full);
            check("R3 par_err", par_err, m_per);
            check("R6 ovr_err", ovr_err, m_ovr);
            check("R4 io_drive_low", io_drive_low, m_drive);
            check("R9 rx_irq", rx_irq, m_full & rx_ie);
            check("R9 err_irq", err_irq, (m_per | m_ovr) & rx_ie);
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    // model of the outcome of one character, timed from the start-bit edge
    task automatic model_char(input logic [7:0] b, input logic p);
        repeat (HALF + 9*ETU + 4) @(posedge clk);
        #1;
        if ((^b) ^ p) begin
            m_data = b;
            m_per  = 1'b1;
            repeat (ETU - HALF - 1) @(posedge clk);
            #1 m_drive = 1'b1;
            repeat (ERRLEN) @(posedge clk);
            #1 m_drive = 1'b0;
        end else if (m_per || m_ovr) begin
            m_data = m_data;
        end else if (m_full) begin
            m_ovr = 1'b1;
        end else begin
            m_data = b;
            m_full = 1'b1;
        end
    endtask

    // send one character; bad=1 inverts the even parity bit
    task automatic send_char(input logic [7:0] b, input logic bad);
        logic p;
        p = (^b) ^ bad;
        @(posedge clk);
        #1 tx_level = 1'b0;
        fork
            model_char(b, p);
        join_none
        for (int i = 0; i < 8; i++) begin
            repeat (ETU) @(posedge clk);
            #1 tx_level = b[i];
        end
        repeat (ETU) @(posedge clk);
        #1 tx_level = p;
        repeat (ETU) @(posedge clk);
        #1 tx_level = 1'b1;
        repeat ((ERRE + 3) * ETU) @(posedge clk);
    endtask

    task automatic pulse_rd();
        @(posedge clk); #1 rd_strobe = 1'b1;
        @(posedge clk); #1 rd_strobe = 1'b0; m_full = 1'b0;
    endtask

    task automatic pulse_per();
        @(posedge clk); #1 per_clr = 1'b1;
        @(posedge clk); #1 per_clr = 1'b0; m_per = 1'b0;
    endtask

    task automatic pulse_ovr();
        @(posedge clk); #1 ovr_clr = 1'b1;
        @(posedge clk); #1 ovr_clr = 1'b0; m_ovr = 1'b0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        cmp_en = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rx_data", rx_data, 0);
        check("R1 flags", {rx_full, par_err, ovr_err, io_drive_low}, 0);
        check("R1 irqs", {rx_irq, err_irq}, 0);

        rx_ie = 1'b1;
        send_char(8'hA5, 1'b0);                // R2 good character
        check("R2 good byte", rx_data, 8'hA5);
        check("R9 rx_irq on good", rx_irq, 1);
        pulse_rd();                            // R8 read clears
        check("R8 read clears full", rx_full, 0);

        send_char(8'h3C, 1'b1);                // R3/R4 bad parity
        check("R3 bad parity flag", par_err, 1);
        check("R3 byte still stored", rx_data, 8'h3C);
        check("R3 full untouched", rx_full, 0);
        pulse_per();
        check("R8 per cleared", par_err, 0);
        send_char(8'h3C, 1'b0);                // R5 retransfer
        check("R5 retransfer received", {rx_full, rx_data}, {1'b1, 8'h3C});

        send_char(8'h81, 1'b0);                // R6 overrun
        check("R6 overrun flag", ovr_err, 1);
        check("R6 old data kept", rx_data, 8'h3C);
        pulse_rd();
        send_char(8'h55, 1'b0);                // R7 discard under ovr_err
        check("R7 discarded under overrun", {rx_full, rx_data}, {1'b0, 8'h3C});
        pulse_ovr();

        rx_ie = 1'b0;
        send_char(8'hFF, 1'b0);                // R9 gated interrupt
        check("R9 irq gated", rx_irq, 0);
        check("R9 full without irq", rx_full, 1);
        pulse_rd();

        @(posedge clk); #1 tx_level = 1'b0;    // R10 short glitch
        repeat (3) @(posedge clk);
        #1 tx_level = 1'b1;
        repeat (2 * ETU) @(posedge clk);
        check("R10 glitch ignored", {rx_full, par_err, ovr_err}, 0);
        send_char(8'h00, 1'b0);
        check("R10 char after glitch", {rx_full, rx_data}, {1'b1, 8'h00});
        pulse_rd();

        send_char(8'h6E, 1'b1);
        send_char(8'h12, 1'b0);                // R7 discard under par_err
        check("R7 discarded under parity error", {rx_full, rx_data}, {1'b0, 8'h6E});
        pulse_per();
        rx_ie = 1'b1;
        send_char(8'hC3, 1'b0);
        check("R2 good after clear", rx_data, 8'hC3);
        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule